// File: doc/BRIEF.md
# Cascadable Product-Term Logic Cell Chain

This block models a row of configurable sum-of-products logic cells, such as those found in the fabric of a programmable logic array. Each cell forms five product terms over a shared input bus. The bus carries three kinds of signal: the data inputs, the register outputs of every cell, and the foldback terms that the cells drive onto a regional bus. Configuration decides which terms feed the cell's OR gate and which serve as control terms. It also decides what drives the second XOR input, how the flip-flop behaves (plain D, toggle or J/K), whether the pin carries the combinational or the registered value, and where clock, clear and output enable come from.

Neighbouring cells can chain their OR sums. With the default eight cells, the last cell of a chain can collect forty product terms. The whole configuration arrives as one flat vector. The register in each cell is a model of a register clocked by a selectable source. It updates on the system clock, and only at edges where the selected clock source is seen rising. Its clear is asynchronous.

Top module: `pterm_chain`

## Requirements
- R1: The bus has width B = NUM_IN + 2*NUM_CELLS. Bit i < NUM_IN is din_i[i]. Bit NUM_IN+c is the register of cell c. Bit NUM_IN+NUM_CELLS+c is fold_o[c]. In cfg_i, cell c owns the slice of width C = 10*B + 22 that starts at bit c*C. Within that slice, term k takes its true-literal mask at [k*B +: B] and its complement-literal mask at [(5+k)*B +: B]. The control word `cell_ctl_t` sits at [10*B +: 22]. A term is the AND of the selected literals, and a term with no literal selected is 1.
- R2: Steer bit k set adds term k to the cell's local OR. A term whose steer bit is clear contributes 0 to the sum.
- R3: A cell's sum is its local OR, ORed with the cascade output of the cell below when casc_en is set. Cell 0 sees 0 from below. casc_o[c] carries cell c's sum.
- R4: The XOR output is the sum XORed with 0, 1 or term 0, for xsrc codes 0, 1 and 2.
- R5: When out_reg is 0, pin_o shows the XOR output. When out_reg is 1, pin_o shows the register.
- R6: The register changes only at a clk_i edge where the selected clock source is 1 and was 0 at the previous edge. The source is gctl_i[clk_idx] when clk_term is 0, and term 1 when clk_term is 1. After rst_i, the source counts as previously high.
- R7: In mode 0 (D), a clock event loads the XOR output.
- R8: In mode 1 (T), a clock event inverts the register when the XOR output is 1 and holds it otherwise.
- R9: In mode 2 (JK), J is the XOR output and K is term 0. On a clock event, 00 holds, 01 clears, 10 sets and 11 inverts.
- R10: The register is cleared at once, with no clock, by any of three sources: rst_i, gctl_i[rst_idx] when rst_src is 1, or term 2 when rst_src is 2.
- R11: oe_o is 1 for oe_src 0, gctl_i[oe_idx] for oe_src 1, term 3 for oe_src 2, and 0 for oe_src 3.
- R12: fold_o[c] carries term 4 of cell c. The regional bus bits are excluded from term 4's masks.
- R13: Other cells' terms can use each cell's register through the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous block reset, active high |
| din_i | input | NUM_IN | Data inputs onto the shared bus |
| gctl_i | input | 4 | Global control lines (clock, clear, enable sources) |
| cfg_i | input | NUM_CELLS*(10*B+22) | Flat configuration of all cells |
| pin_o | output | NUM_CELLS | Cell output values |
| oe_o | output | NUM_CELLS | Cell output enables |
| casc_o | output | NUM_CELLS | Cascade sums |
| fold_o | output | NUM_CELLS | Foldback terms (regional bus) |

## Verification
The bench builds the chain with four data inputs and four cells, which gives a twelve-bit bus. At that size the bench can sweep every data input pattern against all thirty-two steering patterns, and every data pattern against all eight cascade-enable patterns. It also steps each register mode through every J/K and toggle combination. The small bus keeps the foldback and register-feedback paths short, so the bench can check the regional masking and the cross-cell feedback directly at the pins.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

    localparam int NUM_PT   = 5;
    localparam int NUM_GCTL = 4;
    localparam int GIDX_W   = $clog2(NUM_GCTL);

    // fixed control uses of the product terms
    localparam int PT_XOR  = 0;
    localparam int PT_CLK  = 1;
    localparam int PT_CLR  = 2;
    localparam int PT_OE   = 3;
    localparam int PT_FOLD = 4;

    typedef enum logic [1:0] {
        XS_ZERO = 2'd0,
        XS_ONE  = 2'd1,
        XS_TERM = 2'd2,
        XS_RSVD = 2'd3
    } xor_src_e;

    typedef enum logic [1:0] {
        FF_D    = 2'd0,
        FF_T    = 2'd1,
        FF_JK   = 2'd2,
        FF_RSVD = 2'd3
    } ff_mode_e;

    typedef enum logic [1:0] {
        CS_NONE   = 2'd0,
        CS_GLOBAL = 2'd1,
        CS_TERM   = 2'd2,
        CS_RSVD   = 2'd3
    } clr_src_e;

    typedef enum logic [1:0] {
        OE_ON     = 2'd0,
        OE_GLOBAL = 2'd1,
        OE_TERM   = 2'd2,
        OE_OFF    = 2'd3
    } oe_src_e;

    typedef struct packed {
        logic [NUM_PT-1:0] steer;
        xor_src_e          xsrc;
        ff_mode_e          mode;
        logic              out_reg;
        logic              casc_en;
        logic              clk_term;
        logic [GIDX_W-1:0] clk_idx;
        clr_src_e          clr_src;
        logic [GIDX_W-1:0] clr_idx;
        oe_src_e           oe_src;
        logic [GIDX_W-1:0] oe_idx;
    } cell_ctl_t;

    localparam int CTL_W = $bits(cell_ctl_t);

endpackage

// File: rtl/pterm_and.sv
module pterm_and #(
    parameter int W = 24
) (
    input  logic [W-1:0] bus_i,
    input  logic [W-1:0] tmask_i,
    input  logic [W-1:0] cmask_i,
    output logic         term_o
);

    logic [W-1:0] lit_ok;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            lit_ok[i] = (!tmask_i[i] || bus_i[i]) && (!cmask_i[i] || !bus_i[i]);
        end
        term_o = &lit_ok;
    end

endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
    import pterm_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int NUM_CELLS = 8
) (
    input  logic                                  clk_i,
    input  logic                                  rst_i,
    input  logic [NUM_IN+2*NUM_CELLS-1:0]          bus_i,
    input  logic [NUM_GCTL-1:0]                   gctl_i,
    input  logic [NUM_PT*(NUM_IN+2*NUM_CELLS)-1:0] tmask_i,
    input  logic [NUM_PT*(NUM_IN+2*NUM_CELLS)-1:0] cmask_i,
    input  cell_ctl_t                             ctl_i,
    input  logic                                  casc_i,
    output logic                                  pin_o,
    output logic                                  oe_o,
    output logic                                  casc_o,
    output logic                                  fold_o,
    output logic                                  q_o
);

    localparam int BW = NUM_IN + 2 * NUM_CELLS;
    localparam logic [BW-1:0] FOLD_KEEP = {{NUM_CELLS{1'b0}}, {(BW - NUM_CELLS){1'b1}}};

    logic [NUM_PT-1:0] term;

    for (genvar k = 0; k < NUM_PT; k++) begin : g_term
        logic [BW-1:0] tm_k;
        logic [BW-1:0] cm_k;
        if (k == PT_FOLD) begin : g_fold
            // the foldback term never reads the regional bus
            assign tm_k = tmask_i[k*BW +: BW] & FOLD_KEEP;
            assign cm_k = cmask_i[k*BW +: BW] & FOLD_KEEP;
        end else begin : g_full
            assign tm_k = tmask_i[k*BW +: BW];
            assign cm_k = cmask_i[k*BW +: BW];
        end
        pterm_and #(.W(BW)) u_and (
            .bus_i   (bus_i),
            .tmask_i (tm_k),
            .cmask_i (cm_k),
            .term_o  (term[k])
        );
    end

    logic sum_local, sum_all, xin, x_val, nq;
    logic clk_src, clk_rise, cell_clr, rst_any;
    logic q_d, q_q, prev_d, prev_q;

    always_comb begin
        sum_local = |(term & ctl_i.steer);
        sum_all   = sum_local | (ctl_i.casc_en & casc_i);

        case (ctl_i.xsrc)
            XS_ONE:  xin = 1'b1;
            XS_TERM: xin = term[PT_XOR];
            default: xin = 1'b0;
        endcase
        x_val = sum_all ^ xin;

        clk_src  = ctl_i.clk_term ? term[PT_CLK] : gctl_i[ctl_i.clk_idx];
        clk_rise = clk_src & ~prev_q;

        case (ctl_i.clr_src)
            CS_GLOBAL: cell_clr = gctl_i[ctl_i.clr_idx];
            CS_TERM:   cell_clr = term[PT_CLR];
            default:   cell_clr = 1'b0;
        endcase
        rst_any = rst_i | cell_clr;

        case (ctl_i.mode)
            FF_T:    nq = q_q ^ x_val;
            FF_JK:   nq = (x_val & ~q_q) | (~term[PT_XOR] & q_q);
            default: nq = x_val;
        endcase

        q_d    = clk_rise ? nq : q_q;
        prev_d = clk_src;

        case (ctl_i.oe_src)
            OE_GLOBAL: oe_o = gctl_i[ctl_i.oe_idx];
            OE_TERM:   oe_o = term[PT_OE];
            OE_OFF:    oe_o = 1'b0;
            default:   oe_o = 1'b1;
        endcase

        pin_o  = ctl_i.out_reg ? q_q : x_val;
        casc_o = sum_all;
        fold_o = term[PT_FOLD];
        q_o    = q_q;
    end

    always_ff @(posedge clk_i or posedge rst_any) begin
        if (rst_any) q_q <= 1'b0;
        else         q_q <= q_d;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) prev_q <= 1'b1;
        else       prev_q <= prev_d;
    end

    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        cell_clr |-> (q_q == 1'b0)); // R10
    AST_NO_EVENT_HOLD: assert property (@(posedge clk_i) disable iff (rst_any)
        !clk_rise |=> $stable(q_q)); // R6
    AST_D_LOAD: assert property (@(posedge clk_i) disable iff (rst_any)
        (clk_rise && ctl_i.mode == FF_D && $stable(ctl_i)) |=> (q_q == $past(x_val))); // R7
    AST_T_FLIP: assert property (@(posedge clk_i) disable iff (rst_any)
        (clk_rise && ctl_i.mode == FF_T && x_val) |=> (q_q != $past(q_q))); // R8
    AST_JK_SET: assert property (@(posedge clk_i) disable iff (rst_any)
        (clk_rise && ctl_i.mode == FF_JK && x_val && !term[PT_XOR]) |=> q_q); // R9

endmodule

// File: rtl/pterm_chain.sv
module pterm_chain
    import pterm_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int NUM_CELLS = 8
) (
    input  logic                                                 clk_i,
    input  logic                                                 rst_i,
    input  logic [NUM_IN-1:0]                                    din_i,
    input  logic [NUM_GCTL-1:0]                                  gctl_i,
    input  logic [NUM_CELLS*(10*(NUM_IN+2*NUM_CELLS)+CTL_W)-1:0] cfg_i,
    output logic [NUM_CELLS-1:0]                                 pin_o,
    output logic [NUM_CELLS-1:0]                                 oe_o,
    output logic [NUM_CELLS-1:0]                                 casc_o,
    output logic [NUM_CELLS-1:0]                                 fold_o
);

    localparam int BW    = NUM_IN + 2 * NUM_CELLS;
    localparam int MSK_W = NUM_PT * BW;
    localparam int CFG_W = 2 * MSK_W + CTL_W;

    logic [NUM_CELLS-1:0] q_fb;
    logic [BW-1:0]        bus;

    assign bus = {fold_o, q_fb, din_i};

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        cell_ctl_t ctl_c;
        logic      casc_in_c;

        assign ctl_c = cell_ctl_t'(cfg_i[c*CFG_W + 2*MSK_W +: CTL_W]);

        if (c == 0) begin : g_base
            assign casc_in_c = 1'b0;
        end else begin : g_link
            assign casc_in_c = casc_o[c-1];
            AST_CASC_PROPAGATE: assert property (@(posedge clk_i) disable iff (rst_i)
                (ctl_c.casc_en && casc_o[c-1]) |-> casc_o[c]); // R3
        end

        pterm_cell #(.NUM_IN(NUM_IN), .NUM_CELLS(NUM_CELLS)) u_cell (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .bus_i   (bus),
            .gctl_i  (gctl_i),
            .tmask_i (cfg_i[c*CFG_W +: MSK_W]),
            .cmask_i (cfg_i[c*CFG_W + MSK_W +: MSK_W]),
            .ctl_i   (ctl_c),
            .casc_i  (casc_in_c),
            .pin_o   (pin_o[c]),
            .oe_o    (oe_o[c]),
            .casc_o  (casc_o[c]),
            .fold_o  (fold_o[c]),
            .q_o     (q_fb[c])
        );
    end

endmodule

// File: tb/pterm_chain_bench.sv
module pterm_chain_bench;
    import pterm_pkg::*;

    localparam int NI    = 4;
    localparam int NC    = 4;
    localparam int BW    = NI + 2 * NC;
    localparam int CFG_W = 10 * BW + CTL_W;

    logic           clk = 1'b0;
    logic           rst_i = 1'b1;
    logic [NI-1:0]  din_i = '0;
    logic [3:0]     gctl_i = '0;
    logic [NC*CFG_W-1:0] cfg_i = '0;
    logic [NC-1:0]  pin_o, oe_o, casc_o, fold_o;

    logic [BW-1:0] tm [NC][5];
    logic [BW-1:0] cm [NC][5];
    cell_ctl_t     ctl [NC];

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pterm_chain #(.NUM_IN(NI), .NUM_CELLS(NC)) u_pterm_chain (
        .clk_i(clk), .rst_i(rst_i), .din_i(din_i), .gctl_i(gctl_i), .cfg_i(cfg_i),
        .pin_o(pin_o), .oe_o(oe_o), .casc_o(casc_o), .fold_o(fold_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pack();
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 5; k++) begin
                cfg_i[c*CFG_W + k*BW +: BW]     = tm[c][k];
                cfg_i[c*CFG_W + (5+k)*BW +: BW] = cm[c][k];
            end
            cfg_i[c*CFG_W + 10*BW +: CTL_W] = ctl[c];
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst_i = 1'b1; din_i = '0; gctl_i = '0;
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 5; k++) begin tm[c][k] = '0; cm[c][k] = '0; end
            ctl[c] = '0;
        end
        pack();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic go();
        pack();
        @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic apply(input logic [NI-1:0] v);
        @(negedge clk);
        din_i = v;
        #1;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); gctl_i[idx] = 1'b1;
        @(negedge clk); gctl_i[idx] = 1'b0;
        @(negedge clk); #1;
    endtask

    initial begin
        logic [4:0] t;
        logic exp_v, qe, j, kk;
        logic [NC-1:0] ce;

        // reset state with blank configuration
        restart();
        #1;
        chk("R1 reset pin", pin_o, 0);
        chk("R11 reset oe", oe_o, 4'hF);
        chk("R3 reset casc", casc_o, 0);
        chk("R12 reset fold (empty term)", fold_o, 4'hF);

        // R1 R2 R12: steering sweep, term k = d[k]&d[k+1], term4 = ~d0&~d1
        for (int s = 0; s < 32; s++) begin
            restart();
            for (int k = 0; k < 4; k++) tm[0][k] = BW'((1 << k) | (1 << ((k + 1) % 4)));
            cm[0][4] = BW'(3);
            ctl[0].steer = 5'(s);
            go();
            for (int d = 0; d < 16; d++) begin
                apply(NI'(d));
                for (int k = 0; k < 4; k++) t[k] = d[k] & d[(k + 1) % 4];
                t[4] = ~d[0] & ~d[1];
                chk("R2 steered sum", pin_o[0], |(t & 5'(s)));
                if (s == 0) chk("R12 fold term", fold_o[0], t[4]);
            end
        end

        // R1: steered term with no literal is 1
        restart();
        ctl[0].steer = 5'b00100;
        go();
        for (int d = 0; d < 16; d++) begin
            apply(NI'(d));
            chk("R1 empty term", pin_o[0], 1);
        end

        // R3: cascade enable sweep, cell c has term0 = d[c]
        for (int e = 0; e < 8; e++) begin
            restart();
            for (int c = 0; c < NC; c++) begin
                tm[c][0] = BW'(1 << c);
                ctl[c].steer = 5'b00001;
                ctl[c].casc_en = (c > 0) ? e[c-1] : 1'b0;
            end
            go();
            for (int d = 0; d < 16; d++) begin
                apply(NI'(d));
                ce[0] = d[0];
                for (int c = 1; c < NC; c++) ce[c] = d[c] | (e[c-1] & ce[c-1]);
                chk("R3 cascade sums", casc_o, ce);
                chk("R3 cascade pins", pin_o, ce);
            end
        end

        // R4: XOR source
        for (int xs = 0; xs < 3; xs++) begin
            restart();
            tm[0][0] = BW'(8);
            tm[0][1] = BW'(1);
            ctl[0].steer = 5'b00010;
            ctl[0].xsrc = xor_src_e'(xs);
            go();
            for (int d = 0; d < 16; d++) begin
                apply(NI'(d));
                exp_v = d[0] ^ (xs == 0 ? 1'b0 : xs == 1 ? 1'b1 : d[3]);
                chk("R4 xor output", pin_o[0], exp_v);
            end
        end

        // R5 R6 R7 R13: D register on gctl0, cell1 reads cell0 register
        restart();
        tm[0][0] = BW'(1);
        ctl[0].steer = 5'b00001;
        ctl[0].out_reg = 1'b1;
        tm[1][0] = BW'(1 << NI);
        ctl[1].steer = 5'b00001;
        go();
        #1;
        chk("R5 registered pin after reset", pin_o[0], 0);
        for (int n = 0; n < 6; n++) begin
            apply(NI'(n % 3 == 0 ? 1 : 0));
            pulse(0);
            chk("R7 D load", pin_o[0], n % 3 == 0);
            chk("R13 feedback", pin_o[1], n % 3 == 0);
            apply(NI'(n % 3 == 0 ? 0 : 1));
            @(negedge clk); #1;
            chk("R6 no event holds", pin_o[0], n % 3 == 0);
        end
        apply(NI'(1));
        @(negedge clk); gctl_i[0] = 1'b1;
        @(negedge clk); #1;
        chk("R6 first edge", pin_o[0], 1);
        apply(NI'(0));
        @(negedge clk); @(negedge clk); #1;
        chk("R6 level held high", pin_o[0], 1);
        gctl_i[0] = 1'b0;

        // R8: toggle mode
        restart();
        tm[0][0] = BW'(1);
        ctl[0].steer = 5'b00001;
        ctl[0].out_reg = 1'b1;
        ctl[0].mode = FF_T;
        go();
        qe = 1'b0;
        for (int n = 0; n < 8; n++) begin
            apply(NI'((n * 5 + 1) % 3 != 0));
            pulse(0);
            if ((n * 5 + 1) % 3 != 0) qe = ~qe;
            chk("R8 toggle", pin_o[0], qe);
        end

        // R9: JK mode, J = d0 (term1 steered), K = d1 (term0)
        restart();
        tm[0][1] = BW'(1);
        tm[0][0] = BW'(2);
        ctl[0].steer = 5'b00010;
        ctl[0].out_reg = 1'b1;
        ctl[0].mode = FF_JK;
        go();
        qe = 1'b0;
        for (int n = 0; n < 12; n++) begin
            j = n[0] ^ n[2]; kk = n[1];
            apply({2'b00, kk, j});
            pulse(0);
            case ({j, kk})
                2'b01:   qe = 1'b0;
                2'b10:   qe = 1'b1;
                2'b11:   qe = ~qe;
                default: qe = qe;
            endcase
            chk("R9 jk", pin_o[0], qe);
        end

        // R10: clear from a global line, then from term 2
        restart();
        tm[0][0] = BW'(1);
        tm[0][2] = BW'(4);
        ctl[0].steer = 5'b00001;
        ctl[0].out_reg = 1'b1;
        ctl[0].clr_src = CS_GLOBAL;
        ctl[0].clr_idx = 2'd1;
        go();
        apply(NI'(1));
        pulse(0);
        chk("R10 set before clear", pin_o[0], 1);
        @(negedge clk); gctl_i[1] = 1'b1; #1;
        chk("R10 global clear without clock", pin_o[0], 0);
        @(negedge clk); gctl_i[1] = 1'b0;
        ctl[0].clr_src = CS_TERM;
        pack();
        pulse(0);
        chk("R10 set again", pin_o[0], 1);
        @(negedge clk); din_i = 4'b0101; #1;
        chk("R10 term clear without clock", pin_o[0], 0);

        // R6: clock from term 1 = d3, data from term0 = d0
        restart();
        tm[0][0] = BW'(1);
        tm[0][1] = BW'(8);
        ctl[0].steer = 5'b00001;
        ctl[0].out_reg = 1'b1;
        ctl[0].clk_term = 1'b1;
        go();
        for (int n = 0; n < 4; n++) begin
            apply({1'b0, 2'b00, n[0]});
            apply({1'b1, 2'b00, n[0]});
            @(negedge clk); #1;
            chk("R6 term clock", pin_o[0], n[0]);
            apply({1'b0, 2'b00, ~n[0]});
            @(negedge clk); #1;
            chk("R6 term clock hold", pin_o[0], n[0]);
        end

        // R11: output enable sources
        for (int o = 0; o < 4; o++) begin
            restart();
            tm[0][3] = BW'(2);
            ctl[0].oe_src = oe_src_e'(o);
            ctl[0].oe_idx = 2'd2;
            go();
            for (int d = 0; d < 8; d++) begin
                @(negedge clk);
                din_i = {2'b00, d[0], 1'b0};
                gctl_i[2] = d[1];
                #1;
                exp_v = (o == 0) ? 1'b1 : (o == 1) ? d[1] : (o == 2) ? d[0] : 1'b0;
                chk("R11 enable", oe_o[0], exp_v);
            end
        end

        // R12: foldback ignores regional bits; cell2 reads fold of cell1
        restart();
        cm[0][4] = BW'(1);
        tm[1][4] = BW'(4) | BW'(1 << (NI + NC));
        tm[2][0] = BW'(1 << (NI + NC + 1));
        ctl[2].steer = 5'b00001;
        go();
        for (int d = 0; d < 16; d++) begin
            apply(NI'(d));
            chk("R12 fold value", fold_o[1], d[2]);
            chk("R12 regional read", pin_o[2], d[2]);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule